// File: doc/BRIEF.md
# Single-Wire Half-Duplex Serial Port

This block is an asynchronous serial port that moves bytes over either two separate wires (transmit pad and receive pin) or a single shared, bidirectional line. A transmitter and a receiver share the pad through an output-enable. Each has its own bit-rate prescaler, set by a clock divider. A byte offered with a one-cycle strobe is sent as a ten-bit frame. A byte found on the receive path is presented with a one-cycle valid pulse.

With the shared-line select low, the pad is driven at all times and the receiver listens to its dedicated pin. With the select high, the receiver listens to the shared line and the dedicated pin has no effect. The pad driver is switched off whenever no frame is being sent, so another device can talk on the line. The frame on the line while this block transmits is therefore heard by its own receiver. The line is taken as high while nobody drives it, which models an external pull-up. Turning on any of the auxiliary line functions (bus-protocol, clock-output, card or infrared) together with the shared-line select is reported as a configuration error.

Top module: `hd_uart`

## Requirements
- R1: A transmitted frame is a low start bit, then 8 data bits least-significant first, then a high stop bit. Each bit lasts 16*D clock cycles, where D is `baud_div`, and a `baud_div` of 0 counts as 1.
- R2: `tx_busy` rises on the clock edge that accepts `tx_start` and stays high for exactly 160*D cycles.
- R3: A `tx_start` strobe that arrives while `tx_busy` is high is ignored. The frame in flight and its data are unchanged.
- R4: With `half_sel`=1, `pad_oe` is 0 whenever `tx_busy` is 0. With `half_sel`=0, `pad_oe` is always 1.
- R5: `pad_out` is 1 whenever no frame is being sent.
- R6: With `half_sel`=1, the receiver takes the shared line. The line is `pad_out` while `pad_oe` is 1 and `pad_in` otherwise, so the block receives its own frames and also frames driven by another device on `pad_in`.
- R7: With `half_sel`=1, activity on `rx_pin` produces no received byte.
- R8: With `half_sel`=0, the receiver takes `rx_pin`, and activity on `pad_in` produces no received byte.
- R9: A frame received with a high stop bit produces exactly one `rx_valid` pulse of one cycle, with the byte on `rx_data`. A frame whose stop bit is low produces no pulse.
- R10: Each bit is decided by a majority vote of three samples around the bit centre. A low pulse shorter than half a bit on an idle line is rejected as a false start.
- R11: `cfg_err` is 1 exactly when `half_sel`=1 and at least one bit of `aux_en` is 1.
- R12: After reset, `tx_busy`=0, `rx_valid`=0 and `pad_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_sel | input | 1 | 1 selects single-line operation |
| aux_en | input | 4 | Enables for the auxiliary line functions; only checked for conflict |
| baud_div | input | 16 | Clock cycles per oversample tick (0 acts as 1) |
| tx_data | input | 8 | Byte to send |
| tx_start | input | 1 | Send strobe |
| rx_pin | input | 1 | Dedicated receive pin |
| pad_in | input | 1 | Level seen on the pad when not driven by this block |
| pad_out | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad output-enable |
| tx_busy | output | 1 | Frame being sent |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse for a received byte |
| cfg_err | output | 1 | Illegal mode combination |

## Verification
The hardest case to reach from the ports is single-line operation with three sources active at once. The block transmits and so hears its own frame. A second strobe arrives mid-frame. A well-formed frame runs on the unused receive pin at the same time. The bench starts all three together in concurrent threads and expects exactly one byte, the echoed one. It also drives foreign frames on the pad while the driver is released. These include a frame with a low stop bit followed by the rest of that bit, which checks that the receiver does not treat the trailing low level as a new start, and a short glitch on an idle line.

// File: rtl/hd_uart_pkg.sv
package hd_uart_pkg;
  localparam int unsigned OSR = 16;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/hd_uart_baud.sv
module hd_uart_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (div == '0) || (cnt_q >= div - 1'b1);

  always_comb begin
    tick  = last && !restart;
    cnt_d = cnt_q + 1'b1;
    if (restart || last) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hd_uart_tx.sv
module hd_uart_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic [DATA_W-1:0] data,
  input  logic              start,
  output logic              busy,
  output logic              line
);
  import hd_uart_pkg::*;
  localparam int unsigned FRAME = DATA_W + 2;
  localparam int unsigned IDX_W = $clog2(FRAME);
  localparam int unsigned SUB_W = $clog2(OSR);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              accept, tick;

  assign accept = start && !busy_q;

  hd_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .restart(accept), .div(div), .tick(tick)
  );

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sub_d  = sub_q;
    sh_d   = sh_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
      sub_d  = '0;
      sh_d   = data;
    end else if (busy_q && tick) begin
      sub_d = sub_q + 1'b1;
      if (sub_q == SUB_LAST) begin
        if (idx_q == IDX_LAST) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          if (idx_q != '0) sh_d = sh_q >> 1;
        end
      end
    end
  end

  always_comb begin
    if (!busy_q)               line = 1'b1;
    else if (idx_q == '0)      line = 1'b0;
    else if (idx_q == IDX_LAST) line = 1'b1;
    else                       line = sh_q[0];
  end

  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sub_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sub_q  <= sub_d;
      sh_q   <= sh_d;
    end
  end
endmodule

// File: rtl/hd_uart_rx.sv
module hd_uart_rx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              line,
  output logic [DATA_W-1:0] data,
  output logic              valid
);
  import hd_uart_pkg::*;
  localparam int unsigned SUB_W = $clog2(OSR);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [SUB_W-1:0] S_A = SUB_W'(OSR/2 - 1);
  localparam logic [SUB_W-1:0] S_B = SUB_W'(OSR/2);
  localparam logic [SUB_W-1:0] S_C = SUB_W'(OSR/2 + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [1:0]        sync_q;
  rx_state_e         st_q, st_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic [1:0]        smp_q, smp_d;
  logic              val_q, val_d;
  logic              tick, s, maj;

  hd_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .restart(1'b0), .div(div), .tick(tick)
  );

  assign s   = sync_q[1];
  assign maj = (smp_q[0] & smp_q[1]) | (smp_q[0] & s) | (smp_q[1] & s);

  always_comb begin
    st_d  = st_q;
    sub_d = sub_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    out_d = out_q;
    smp_d = smp_q;
    val_d = 1'b0;
    if (tick) begin
      if (st_q == RX_IDLE) begin
        if (!s) begin
          st_d  = RX_START;
          sub_d = '0;
        end
      end else begin
        sub_d = sub_q + 1'b1;
        if (sub_q == S_A) smp_d[0] = s;
        if (sub_q == S_B) smp_d[1] = s;
        if (sub_q == S_C) begin
          case (st_q)
            RX_START: begin
              if (maj) st_d = RX_IDLE;
              else begin
                st_d  = RX_DATA;
                cnt_d = '0;
              end
            end
            RX_DATA: begin
              sh_d = {maj, sh_q[DATA_W-1:1]};
              if (cnt_q == CNT_LAST) st_d = RX_STOP;
              else                   cnt_d = cnt_q + 1'b1;
            end
            default: begin
              if (maj) begin
                val_d = 1'b1;
                out_d = sh_q;
              end
              st_d = RX_IDLE;
            end
          endcase
        end
      end
    end
  end

  assign data  = out_q;
  assign valid = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      sub_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      out_q  <= '0;
      smp_q  <= 2'b11;
      val_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line};
      st_q   <= st_d;
      sub_q  <= sub_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      out_q  <= out_d;
      smp_q  <= smp_d;
      val_q  <= val_d;
    end
  end
endmodule

// File: rtl/hd_uart.sv
module hd_uart #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned AUX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_sel,
  input  logic [AUX_W-1:0]  aux_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_start,
  input  logic              rx_pin,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              tx_busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              cfg_err
);
  logic tx_line, rx_src, shared_line;

  hd_uart_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .data(tx_data),
    .start(tx_start), .busy(tx_busy), .line(tx_line)
  );

  assign pad_out     = tx_line;
  assign pad_oe      = !half_sel || tx_busy;
  assign shared_line = pad_oe ? tx_line : pad_in;
  assign rx_src      = half_sel ? shared_line : rx_pin;
  assign cfg_err     = half_sel && (|aux_en);

  hd_uart_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .line(rx_src),
    .data(rx_data), .valid(rx_valid)
  );
endmodule

// File: rtl/hd_uart_chk.sv
module hd_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic half_sel,
  input logic tx_start,
  input logic pad_out,
  input logic pad_oe,
  input logic tx_busy,
  input logic rx_valid
);
  // R4
  released_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_sel && !tx_busy) |-> !pad_oe);
  // R4
  driven_in_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_sel |-> pad_oe);
  // R5
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> pad_out);
  // R1
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !pad_out);
  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_start));
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind hd_uart hd_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .half_sel(half_sel), .tx_start(tx_start),
  .pad_out(pad_out), .pad_oe(pad_oe), .tx_busy(tx_busy), .rx_valid(rx_valid)
);

// File: tb/hd_uart_tb.sv
module hd_uart_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_sel = 1'b0;
  logic [3:0] aux_en = 4'h0;
  logic [15:0] baud_div = 16'd2;
  logic [7:0] tx_data = 8'h00;
  logic       tx_start = 1'b0;
  logic       rx_pin = 1'b1;
  logic       pad_in = 1'b1;
  logic       pad_out, pad_oe, tx_busy, rx_valid, cfg_err;
  logic [7:0] rx_data;

  int checks = 0;
  int fails  = 0;

  // reference model state
  bit       m_busy = 0;
  int       m_c = 0;
  int       m_d = 1;
  bit [7:0] m_byte = 0;
  byte unsigned expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hd_uart u_dut (
    .clk(clk), .rst_n(rst_n), .half_sel(half_sel), .aux_en(aux_en),
    .baud_div(baud_div), .tx_data(tx_data), .tx_start(tx_start),
    .rx_pin(rx_pin), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .tx_busy(tx_busy), .rx_data(rx_data), .rx_valid(rx_valid), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_div();
    return (baud_div == 0) ? 1 : int'(baud_div);
  endfunction

  function automatic bit m_line();
    int b;
    if (!m_busy) return 1'b1;
    b = m_c / (16 * m_d);
    if (b == 0) return 1'b0;
    if (b == 9) return 1'b1;
    return m_byte[b-1];
  endfunction

  // behavioural model of the transmitter, advanced on every clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0;
    end else if (m_busy) begin
      m_c++;
      if (m_c == 160 * m_d) m_busy = 0;
    end else if (tx_start) begin
      m_busy = 1;
      m_c    = 0;
      m_d    = eff_div();
      m_byte = tx_data;
      if (half_sel) expq.push_back(tx_data);
    end
  end

  // comparison a quarter period after each edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      check("R2 tx_busy", tx_busy == m_busy, tx_busy, m_busy);
      check("R1/R3/R5 pad_out", pad_out == m_line(), pad_out, m_line());
      check("R4 pad_oe", pad_oe == (!half_sel || m_busy), pad_oe, (!half_sel || m_busy));
      if (rx_valid) begin
        if (expq.size() == 0) check("R7/R8/R9/R10 unexpected rx_valid", 1'b0, rx_data, -1);
        else begin
          byte unsigned e;
          e = expq.pop_front();
          check("R6/R9 rx_data", rx_data == e, rx_data, e);
        end
      end
    end
  end

  task automatic send_tx(input bit [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  // drive a frame on the dedicated pin (to_pad=0) or on the pad (to_pad=1)
  task automatic ext_frame(input bit to_pad, input bit [7:0] b, input bit stop_v, input int bitclk);
    for (int i = 0; i < 10; i++) begin
      bit v;
      v = (i == 0) ? 1'b0 : (i == 9) ? stop_v : b[i-1];
      for (int k = 0; k < bitclk; k++) begin
        @(negedge clk);
        if (to_pad) pad_in = v; else rx_pin = v;
      end
    end
    @(negedge clk);
    if (to_pad) pad_in = 1'b1; else rx_pin = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drained(input string req);
    check(req, expq.size() == 0, expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    #(WATCHDOG * CLK_PERIOD);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R12 reset state
    check("R12 tx_busy", tx_busy == 1'b0, tx_busy, 0);
    check("R12 rx_valid", rx_valid == 1'b0, rx_valid, 0);
    check("R12 pad_out", pad_out == 1'b1, pad_out, 1);

    // R8: full duplex, receive from rx_pin, ignore pad_in, transmit on pad
    expq.push_back(8'h3C);
    fork
      send_tx(8'hA5);
      ext_frame(1'b0, 8'h3C, 1'b1, 32);
      ext_frame(1'b1, 8'h0F, 1'b1, 32);
    join
    idle(100);
    drained("R8 full-duplex receive");

    // R6 echo, R3 ignored strobe, R7 rx_pin ignored in half mode
    half_sel = 1'b1;
    idle(20);
    fork
      send_tx(8'h5A);
      begin idle(100); send_tx(8'hFF); end
      ext_frame(1'b0, 8'h00, 1'b1, 32);
    join
    idle(150);
    drained("R6/R7 half echo only");

    // R6: foreign device on the released pad
    expq.push_back(8'hC3);
    ext_frame(1'b1, 8'hC3, 1'b1, 32);
    idle(60);
    drained("R6 foreign frame on pad");

    // R10: short glitch rejected
    @(negedge clk); pad_in = 1'b0;
    idle(4);
    pad_in = 1'b1;
    idle(120);
    drained("R10 glitch");

    // R9: low stop bit produces no byte
    ext_frame(1'b1, 8'h96, 1'b0, 32);
    idle(120);
    drained("R9 framing error");

    // R1: divider 0 acts as 1, full mode
    half_sel = 1'b0;
    baud_div = 16'd0;
    idle(20);
    expq.push_back(8'h7E);
    fork
      send_tx(8'h81);
      ext_frame(1'b0, 8'h7E, 1'b1, 16);
    join
    idle(60);
    drained("R1 divider zero");

    // R11 configuration conflict
    for (int m = 0; m < 32; m++) begin
      @(negedge clk);
      half_sel = m[4];
      aux_en   = m[3:0];
      #1;
      check("R11 cfg_err", cfg_err == (m[4] && (m[3:0] != 0)), cfg_err, (m[4] && (m[3:0] != 0)));
    end
    aux_en = 4'h0;
    half_sel = 1'b0;
    idle(5);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule